// File: doc/BRIEF.md
# Processor Bus Machine-Cycle Sequencer

This block produces the external bus timing of a small 8-bit processor. Each instruction is carried out as a series of machine cycles, and each machine cycle lasts a whole number of T-states, where one T-state is one clock period. A controller asks for one machine cycle at a time. It gives a cycle kind, a 16-bit address and, for writes, a data byte. The sequencer then runs that cycle on the bus. It drives the three status lines, a one-clock address-latch strobe, active-low read, write and interrupt-acknowledge strobes, the address bus and the outgoing data bus.

When the cycle ends, the sequencer raises a done pulse. On cycles that read, it holds the byte captured from the bus. An opcode fetch normally takes four T-states: three for the bus access and one for internal work with no strobe active. A per-request stretch flag lengthens the fetch to six T-states for instructions that need extra internal time before their next bus cycle.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, and whenever no cycle is running, the status lines {iom,s1,s0} read 000, ale is 0, rd_n, wr_n and inta_n are 1, busy is 0, bus_addr and bus_dout are 0, dout_en is 0, and rdata is 0 until the first capture.
- R2: A request is taken only at a clock edge where req_valid is 1 while the block is idle and req_kind is 0 to 5. Kind codes 6 and 7 are ignored and leave the block idle. Requests and changes to the request inputs while a cycle runs have no effect on that cycle.
- R3: While a cycle runs, {iom,s1,s0} show: kind 0 opcode fetch 011, kind 1 memory read 010, kind 2 memory write 001, kind 3 I/O read 110, kind 4 I/O write 101, kind 5 interrupt acknowledge 111.
- R4: T1 is the clock cycle right after the request is taken. Cycle length is 4 T-states for a fetch, 6 T-states for a fetch with req_long set, 4 T-states for interrupt acknowledge (req_long ignored), and 3 T-states for the four read and write kinds.
- R5: ale is 1 in T1 only. bus_addr carries the requested address in every T-state of the cycle.
- R6: rd_n is 0 in T2 and T3 of fetch, memory read and I/O read, and 1 at all other times.
- R7: wr_n is 0 in T2 and T3 of memory write and I/O write. In those same T-states dout_en is 1 and bus_dout carries the request byte. At all other times dout_en is 0 and bus_dout is 0.
- R8: inta_n is 0 in T2 and T3 of interrupt acknowledge, and rd_n stays 1 for that kind.
- R9: For fetch, memory read, I/O read and interrupt acknowledge, rdata takes the value of bus_din at the clock edge that ends T3. Write cycles leave rdata unchanged.
- R10: done is 1 for exactly the final T-state of each cycle, and busy is 1 from T1 through that final T-state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one T-state |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request a machine cycle |
| req_kind | input | 3 | Cycle kind code (0 to 5) |
| req_long | input | 1 | Stretch an opcode fetch to 6 T-states |
| req_addr | input | 16 | Address for the cycle |
| req_wdata | input | 8 | Byte to write |
| bus_din | input | 8 | Data bus input |
| bus_addr | output | 16 | Address bus |
| bus_dout | output | 8 | Data bus output |
| dout_en | output | 1 | Data bus output enable |
| st_iom | output | 1 | Status: I/O (1) or memory (0) |
| st_s1 | output | 1 | Status line 1 |
| st_s0 | output | 1 | Status line 0 |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Interrupt-acknowledge strobe, active low |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | Final T-state of the cycle |
| busy | output | 1 | A cycle is running |

## Verification
Completion of one cycle and arrival of the next request can overlap. In the final T-state, done is high and req_valid may already be high, but the block must not take the request until it is idle. The bench keeps req_valid asserted through whole cycles, changing kind and address halfway. It then checks that the running cycle keeps its original status and address, that exactly one idle clock follows done, and that T1 of the waiting request comes next. On 3-T read cycles, the read-data capture also lands at the same edge as the end of done. The bench checks that the captured byte is the one driven on bus_din during T3.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   typedef enum logic [2:0] {
      CY_FETCH = 3'd0,
      CY_MRD   = 3'd1,
      CY_MWR   = 3'd2,
      CY_IORD  = 3'd3,
      CY_IOWR  = 3'd4,
      CY_INTA  = 3'd5
   } cyc_e;

   localparam logic [2:0] STATUS_IDLE = 3'b000;

   function automatic logic kind_ok(input logic [2:0] k);
      return (k <= 3'd5);
   endfunction

   // {iom, s1, s0}
   function automatic logic [2:0] status_of(input cyc_e k);
      case (k)
         CY_FETCH: return 3'b011;
         CY_MRD:   return 3'b010;
         CY_MWR:   return 3'b001;
         CY_IORD:  return 3'b110;
         CY_IOWR:  return 3'b101;
         CY_INTA:  return 3'b111;
         default:  return STATUS_IDLE;
      endcase
   endfunction

   function automatic logic uses_rd(input cyc_e k);
      return (k == CY_FETCH) || (k == CY_MRD) || (k == CY_IORD);
   endfunction

   function automatic logic uses_wr(input cyc_e k);
      return (k == CY_MWR) || (k == CY_IOWR);
   endfunction

   function automatic logic captures(input cyc_e k);
      return uses_rd(k) || (k == CY_INTA);
   endfunction

endpackage

// File: rtl/bcs_timer.sv
module bcs_timer
   import bcs_pkg::*;
#(
   parameter int FETCH_T      = 4,
   parameter int FETCH_LONG_T = 6,
   parameter int RW_T         = 3,
   parameter int TW           = $clog2(FETCH_LONG_T + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  cyc_e          start_kind,
   input  logic          start_long,
   output logic          active,
   output logic [TW-1:0] tstate,
   output logic          last
);

   logic [TW-1:0] len_q;
   logic [TW-1:0] len_sel;

   always_comb begin
      case (start_kind)
         CY_FETCH: len_sel = start_long ? TW'(FETCH_LONG_T) : TW'(FETCH_T);
         CY_INTA:  len_sel = TW'(FETCH_T);
         default:  len_sel = TW'(RW_T);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         tstate <= '0;
         len_q  <= '0;
      end else if (start) begin
         active <= 1'b1;
         tstate <= TW'(1);
         len_q  <= len_sel;
      end else if (active) begin
         if (tstate == len_q) begin
            active <= 1'b0;
            tstate <= '0;
         end else begin
            tstate <= tstate + TW'(1);
         end
      end
   end

   assign last = active && (tstate == len_q);

   // R4: the cycle after acceptance is T1
   a_r4_start_t1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (active && tstate == TW'(1)));

   // R10: the final T-state is followed by an idle clock
   a_r10_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !active);

endmodule

// File: rtl/bcs_strobes.sv
module bcs_strobes
   import bcs_pkg::*;
#(
   parameter int TW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic [TW-1:0] tstate,
   input  cyc_e          kind,
   output logic          ale,
   output logic          rd_n,
   output logic          wr_n,
   output logic          inta_n,
   output logic          dout_en
);

   logic strobe_window;

   assign strobe_window = active && (tstate == TW'(2) || tstate == TW'(3));

   always_comb begin
      ale     = active && (tstate == TW'(1));
      rd_n    = !(strobe_window && uses_rd(kind));
      wr_n    = !(strobe_window && uses_wr(kind));
      inta_n  = !(strobe_window && (kind == CY_INTA));
      dout_en = strobe_window && uses_wr(kind);
   end

   // R5: the latch strobe lasts exactly one clock
   a_r5_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   // R6 R7: read and write strobes never overlap
   a_r6_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n));

   // R8: acknowledge strobe excludes the read strobe
   a_r8_inta_no_rd: assert property (@(posedge clk) disable iff (!rst_n)
      !inta_n |-> rd_n);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
   import bcs_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int DATA_W         = 8,
   parameter int FETCH_T        = 4,
   parameter int FETCH_LONG_T   = 6,
   parameter int RW_T           = 3,
   parameter bit IDLE_ADDR_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_kind,
   input  logic              req_long,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] bus_din,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              dout_en,
   output logic              st_iom,
   output logic              st_s1,
   output logic              st_s0,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              inta_n,
   output logic [DATA_W-1:0] rdata,
   output logic              done,
   output logic              busy
);

   localparam int TW = $clog2(FETCH_LONG_T + 1);

   generate
      if (FETCH_T < 4)
         $error("FETCH_T must leave at least one internal T-state after T3");
      if (FETCH_LONG_T <= FETCH_T)
         $error("FETCH_LONG_T must exceed FETCH_T");
      if (RW_T < 3)
         $error("RW_T must cover T1 to T3");
      if (ADDR_W < 1 || DATA_W < 1)
         $error("bus widths must be positive");
   endgenerate

   logic              start;
   logic              active;
   logic [TW-1:0]     tstate;
   logic              last;
   cyc_e              kind_q;
   cyc_e              kind_in;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic [2:0]        status;

   assign kind_in = cyc_e'(req_kind);
   assign start   = req_valid && !active && kind_ok(req_kind);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q  <= CY_FETCH;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (start) begin
         kind_q  <= kind_in;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (active && tstate == TW'(3) && captures(kind_q))
         rdata_q <= bus_din;
   end

   bcs_timer #(
      .FETCH_T      (FETCH_T),
      .FETCH_LONG_T (FETCH_LONG_T),
      .RW_T         (RW_T),
      .TW           (TW)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_kind (kind_in),
      .start_long (req_long),
      .active     (active),
      .tstate     (tstate),
      .last       (last)
   );

   bcs_strobes #(
      .TW (TW)
   ) u_strobes (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (active),
      .tstate  (tstate),
      .kind    (kind_q),
      .ale     (ale),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .inta_n  (inta_n),
      .dout_en (dout_en)
   );

   assign status = active ? status_of(kind_q) : STATUS_IDLE;
   assign st_iom = status[2];
   assign st_s1  = status[1];
   assign st_s0  = status[0];

   generate
      if (IDLE_ADDR_ZERO) begin : g_addr_zero
         assign bus_addr = active ? addr_q : '0;
      end else begin : g_addr_hold
         assign bus_addr = addr_q;
      end
   endgenerate

   assign bus_dout = dout_en ? wdata_q : '0;
   assign rdata    = rdata_q;
   assign done     = last;
   assign busy     = active;

   // R10: completion returns the bus to the idle encoding
   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && {st_iom, st_s1, st_s0} == STATUS_IDLE));

   // R2: a running cycle keeps its kind and address
   a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> ($stable(kind_q) && $stable(addr_q)));

   // R6: a read-kind T1 is followed by the read strobe
   a_r6_ale_then_rd: assert property (@(posedge clk) disable iff (!rst_n)
      (ale && uses_rd(kind_q)) |=> !rd_n);

   // R9: captured data only changes after a T3
   a_r9_rdata_t3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdata_q) |-> $past(active && tstate == TW'(3)));

endmodule

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_kind = 3'd0;
   logic        req_long = 1'b0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0]  req_wdata = 8'h0;
   logic [7:0]  bus_din = 8'h0;
   logic [15:0] bus_addr;
   logic [7:0]  bus_dout;
   logic        dout_en, st_iom, st_s1, st_s0, ale, rd_n, wr_n, inta_n, done, busy;
   logic [7:0]  rdata;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [7:0] exp_rdata = 8'h00;

   bus_cycle_seq uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_long(req_long), .req_addr(req_addr), .req_wdata(req_wdata),
      .bus_din(bus_din), .bus_addr(bus_addr), .bus_dout(bus_dout),
      .dout_en(dout_en), .st_iom(st_iom), .st_s1(st_s1), .st_s0(st_s0),
      .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .rdata(rdata),
      .done(done), .busy(busy)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 50000) begin
         errors++;
         $display("FAIL watchdog: actual=%0d cycles expected=<50000", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_len(input logic [2:0] k, input logic lng);
      if (k == 3'd0) return lng ? 6 : 4;
      if (k == 3'd5) return 4;
      return 3;
   endfunction

   function automatic logic [2:0] exp_status(input logic [2:0] k);
      case (k)
         3'd0: return 3'b011;
         3'd1: return 3'b010;
         3'd2: return 3'b001;
         3'd3: return 3'b110;
         3'd4: return 3'b101;
         3'd5: return 3'b111;
         default: return 3'b000;
      endcase
   endfunction

   function automatic logic is_rdk(input logic [2:0] k);
      return k == 3'd0 || k == 3'd1 || k == 3'd3;
   endfunction

   function automatic logic is_wrk(input logic [2:0] k);
      return k == 3'd2 || k == 3'd4;
   endfunction

   task automatic chk_idle(input string tag);
      chk({tag, " R1 status"}, {st_iom, st_s1, st_s0}, 3'b000);
      chk({tag, " R1 strobes"}, {ale, rd_n, wr_n, inta_n, dout_en}, 5'b01110);
      chk({tag, " R1 busy/done"}, {busy, done}, 2'b00);
      chk({tag, " R1 buses"}, {bus_addr, bus_dout}, 24'h0);
   endtask

   // Called just after a falling edge; returns just after a falling edge in the idle clock.
   task automatic run_cycle(input logic [2:0] k, input logic lng, input logic [15:0] a,
                            input logic [7:0] wd, input logic [7:0] din, input logic hold);
      int n;
      logic strb;
      n = exp_len(k, lng);
      req_valid = 1'b1; req_kind = k; req_long = lng; req_addr = a; req_wdata = wd;
      @(negedge clk);
      if (hold) begin
         req_kind = (k == 3'd1) ? 3'd4 : 3'd1;
         req_long = ~lng;
         req_addr = ~a;
         req_wdata = ~wd;
      end else begin
         req_valid = 1'b0;
      end
      bus_din = din;
      for (int t = 1; t <= n; t++) begin
         strb = (t == 2 || t == 3);
         chk("R3 status", {st_iom, st_s1, st_s0}, exp_status(k));
         chk("R5 ale", ale, t == 1);
         chk("R5 addr", bus_addr, a);
         chk("R6 rd_n", rd_n, !(strb && is_rdk(k)));
         chk("R7 wr_n", wr_n, !(strb && is_wrk(k)));
         chk("R7 dout", {dout_en, bus_dout}, (strb && is_wrk(k)) ? {1'b1, wd} : 9'h0);
         chk("R8 inta_n", inta_n, !(strb && k == 3'd5));
         chk("R10 done/busy", {done, busy}, {t == n, 1'b1});
         @(negedge clk);
      end
      if (k != 3'd2 && k != 3'd4) exp_rdata = din;
      chk("R4 length end", busy, 1'b0);
      chk_idle("R10 after done");
      chk("R9 rdata", rdata, exp_rdata);
   endtask

   initial begin
      void'($urandom(32'd2024));
      #35;
      chk_idle("reset");
      chk("R1 rdata reset", rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      chk_idle("after reset");

      // R2: invalid kind codes are ignored
      req_valid = 1'b1; req_kind = 3'd6; req_addr = 16'hBEEF;
      @(negedge clk);
      chk_idle("R2 kind6");
      req_kind = 3'd7;
      @(negedge clk);
      chk_idle("R2 kind7");
      req_valid = 1'b0;
      @(negedge clk);

      // Directed corner cases
      run_cycle(3'd0, 1'b0, 16'h2000, 8'h00, 8'h3E, 1'b0);   // R4 fetch 4T
      run_cycle(3'd1, 1'b0, 16'h2001, 8'h00, 8'h5A, 1'b0);   // R9 operand read
      run_cycle(3'd0, 1'b1, 16'h2002, 8'h00, 8'hC5, 1'b0);   // R4 long fetch 6T
      run_cycle(3'd5, 1'b1, 16'h0038, 8'h00, 8'hFF, 1'b0);   // R4 R8 inta ignores long
      run_cycle(3'd2, 1'b0, 16'h8000, 8'hA5, 8'h11, 1'b0);   // R7 R9 write keeps rdata
      run_cycle(3'd4, 1'b1, 16'h00FE, 8'h3C, 8'h22, 1'b0);   // R7 io write
      run_cycle(3'd3, 1'b0, 16'h0042, 8'h00, 8'h77, 1'b1);   // R2 held request
      run_cycle(3'd1, 1'b0, 16'hFFFF, 8'h00, 8'h00, 1'b1);   // R2 back-to-back
      run_cycle(3'd0, 1'b1, 16'h0000, 8'h00, 8'h81, 1'b0);

      // Constrained random
      for (int i = 0; i < 80; i++) begin
         run_cycle(3'($urandom_range(0, 5)), 1'($urandom_range(0, 1)),
                   16'($urandom), 8'($urandom), 8'($urandom),
                   ($urandom_range(0, 3) == 0));
      end
      req_valid = 1'b0;
      @(negedge clk);
      chk_idle("final");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule